// File: doc/BRIEF.md
# Programmable Line-Buffer 3x3 Window Generator

This block takes a raster-ordered stream of 8-bit pixels, one row after another and not interlaced, and turns it into a 3x3 neighbourhood for a downstream convolution datapath. Two internal line delays each hold one row, and their length is set in a row-length register. Together with the live pixel they give three vertically aligned samples on every accepted pixel. Each of the three rows then passes through a three-stage horizontal shift to form the window. A cascade output gives the live pixel delayed by two rows, so another stage can be chained after this one.

A configuration bit switches to external-row operation. In that mode the two upper window rows come from a 16-bit external input instead of the internal line delays, so longer rows can be held outside the block.

Pixels enter through a valid/ready handshake. The input is back-pressured only by the hold control. The window output has no ready signal, and a consumer must take it on every cycle in which it changes. An active-low frame input clears the datapath and keeps the configuration. Hold freezes every register one cycle after it is sampled high.

Top module: `lbw_window_gen`

## Requirements
- R1: After `rst_n` is released, all window taps and `casc_out` are 0, `win_valid` is 0, and `in_ready` is 1.
- R2: `in_ready` equals the inverse of `hold` as sampled at the previous rising edge. A pixel is accepted only on an edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` low leave every output unchanged.
- R3: Window row 0 (`win_flat` bytes 0..2, byte index = row*3 + column) holds the pixels accepted 0, 1 and 2 accepts ago. Column 0 is the newest.
- R4: In internal mode, row r (r = 1, 2; bytes 3..5 and 6..8) column c holds the pixel accepted r*L + c accepts ago, where L is the row length. A tap is 0 until that many pixels have been accepted since the last frame reset.
- R5: `casc_out` holds the pixel accepted 2*L accepts ago, or 0 before 2*L+1 accepts. This holds in both modes.
- R6: `win_valid` is 1 exactly when at least 2*L+3 pixels have been accepted since the last frame reset.
- R7: With the external-row bit set, row 1 column c holds `ext_rows[7:0]` and row 2 column c holds `ext_rows[15:8]`, as sampled c accepts ago.
- R8: A configuration write (`cfg_we` high while `in_ready` is 1) loads L from `cfg_len` and the mode from `cfg_ext`. A length of 0 or above 1024 gives L = 1024. A write while `in_ready` is 0 is ignored.
- R9: While `frame_n` is low, all taps, `casc_out`, `win_valid` and the fill state are cleared asynchronously. L and the mode are kept.
- R10: While `in_ready` is 0, the window, `casc_out` and `win_valid` do not change, whatever `in_valid` and `in_pix` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous full reset, active low |
| frame_n | input | 1 | Asynchronous new-frame clear, active low; configuration kept |
| hold | input | 1 | Freeze request, takes effect one cycle after sampling |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | 11 | Requested row length |
| cfg_ext | input | 1 | External-row mode select |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel can be accepted |
| in_pix | input | 8 | Pixel data |
| ext_rows | input | 16 | External rows: [7:0] row 1, [15:8] row 2 |
| win_flat | output | 72 | 3x3 window, byte row*3+column |
| win_valid | output | 1 | Window fully populated |
| casc_out | output | 8 | Pixel delayed by two rows |

## Verification
The case of interest is a frame reset that arrives while a hold is in force. The frame clear must win over the freeze, and the configuration must still survive. The bench raises hold, waits until `in_ready` drops, drives `frame_n` low across a clock edge with hold still high, and checks that every tap, `casc_out` and `win_valid` read zero. It then releases hold and refills the frame. The refill is judged against the earlier row length: the window-valid boundary and the two-row-delayed taps must appear at the counts that the unchanged length predicts.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  localparam int WIN_ROWS = 3;
  localparam int WIN_COLS = 3;
  localparam int LINE_CNT = WIN_ROWS - 1;

  // Out-of-range lengths select the full line capacity
  function automatic int clamp_len(input int req, input int max_len);
    if (req == 0 || req > max_len) return max_len;
    return req;
  endfunction
endpackage

// File: rtl/lbw_ctrl.sv
module lbw_ctrl #(
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = 11,
  parameter int AW      = 10,
  parameter int CNT_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_rst_n,
  input  logic             hold,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_ext,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             adv,
  output logic [AW-1:0]    addr,
  output logic             wrap,
  output logic             ext_mode,
  output logic             win_valid
);
  import lbw_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(2 * MAX_LEN + 3);

  logic             hold_q;
  logic [LEN_W-1:0] row_len;
  logic [LEN_W-1:0] len_last;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] fill_need;

  // hold takes effect one cycle after it is sampled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold;
  end

  assign in_ready = !hold_q;
  assign adv      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_len  <= LEN_W'(MAX_LEN);
      ext_mode <= 1'b0;
    end else if (cfg_we && in_ready) begin
      row_len  <= LEN_W'(clamp_len(int'(cfg_len), MAX_LEN));
      ext_mode <= cfg_ext;
    end
  end

  assign len_last = row_len - LEN_W'(1);
  assign wrap     = (LEN_W'(addr) >= len_last);

  always_ff @(posedge clk or negedge dp_rst_n) begin
    if (!dp_rst_n)  addr <= '0;
    else if (adv)   addr <= wrap ? '0 : addr + AW'(1);
  end

  always_ff @(posedge clk or negedge dp_rst_n) begin
    if (!dp_rst_n)                      fill_cnt <= '0;
    else if (adv && fill_cnt < CNT_LIM) fill_cnt <= fill_cnt + CNT_W'(1);
  end

  assign fill_need = (CNT_W'(row_len) << 1) + CNT_W'(3);
  assign win_valid = (fill_cnt >= fill_need);
endmodule

// File: rtl/lbw_line_delay.sv
module lbw_line_delay #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [AW-1:0]    addr,
  input  logic             wrap,
  input  logic             prev_full,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] dout,
  output logic             full
);
  logic [PIX_W-1:0] mem [DEPTH];

  // read-before-write at the shared address
  always_ff @(posedge clk) begin
    if (adv) mem[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          full <= 1'b0;
    else if (adv && wrap && prev_full)   full <= 1'b1;
  end

  assign dout = full ? mem[addr] : '0;
endmodule

// File: rtl/lbw_row_shift.sv
module lbw_row_shift #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [PIX_W-1:0]      din,
  output logic [TAPS*PIX_W-1:0] taps
);
  logic [PIX_W-1:0] stage [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) stage[k] <= '0;
    end else if (adv) begin
      stage[0] <= din;
      for (int k = 1; k < TAPS; k++) stage[k] <= stage[k-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign taps[k*PIX_W +: PIX_W] = stage[k];
  end
endmodule

// File: rtl/lbw_window_gen.sv
module lbw_window_gen #(
  parameter int  PIX_W   = 8,
  parameter int  MAX_LEN = 1024,
  localparam int LEN_W   = $clog2(MAX_LEN) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               hold,
  input  logic               cfg_we,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_ext,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic [2*PIX_W-1:0] ext_rows,
  output logic [9*PIX_W-1:0] win_flat,
  output logic               win_valid,
  output logic [PIX_W-1:0]   casc_out
);
  import lbw_pkg::*;

  localparam int AW    = $clog2(MAX_LEN);
  localparam int CNT_W = LEN_W + 2;

  logic             dp_rst_n;
  logic             adv;
  logic             wrap;
  logic             ext_mode;
  logic [AW-1:0]    addr;
  logic [PIX_W-1:0] ld_in  [LINE_CNT];
  logic [PIX_W-1:0] ld_out [LINE_CNT];
  logic [LINE_CNT-1:0] ld_full;
  logic [LINE_CNT-1:0] ld_prev;
  logic [PIX_W-1:0] row_src [WIN_ROWS];
  logic [PIX_W-1:0] casc_q;

  assign dp_rst_n = rst_n & frame_n;

  lbw_ctrl #(
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .AW(AW), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dp_rst_n (dp_rst_n),
    .hold     (hold),
    .cfg_we   (cfg_we),
    .cfg_len  (cfg_len),
    .cfg_ext  (cfg_ext),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .adv      (adv),
    .addr     (addr),
    .wrap     (wrap),
    .ext_mode (ext_mode),
    .win_valid(win_valid)
  );

  for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
    if (i == 0) begin : g_first
      assign ld_in[i]   = in_pix;
      assign ld_prev[i] = 1'b1;
    end else begin : g_next
      assign ld_in[i]   = ld_out[i-1];
      assign ld_prev[i] = ld_full[i-1];
    end
    lbw_line_delay #(
      .PIX_W(PIX_W), .DEPTH(MAX_LEN), .AW(AW)
    ) u_line (
      .clk      (clk),
      .rst_n    (dp_rst_n),
      .adv      (adv),
      .addr     (addr),
      .wrap     (wrap),
      .prev_full(ld_prev[i]),
      .din      (ld_in[i]),
      .dout     (ld_out[i]),
      .full     (ld_full[i])
    );
  end

  for (genvar r = 0; r < WIN_ROWS; r++) begin : g_row
    if (r == 0) begin : g_live
      assign row_src[r] = in_pix;
    end else begin : g_upper
      assign row_src[r] = ext_mode ? ext_rows[(r-1)*PIX_W +: PIX_W]
                                   : ld_out[r-1];
    end
    lbw_row_shift #(
      .PIX_W(PIX_W), .TAPS(WIN_COLS)
    ) u_shift (
      .clk  (clk),
      .rst_n(dp_rst_n),
      .adv  (adv),
      .din  (row_src[r]),
      .taps (win_flat[r*WIN_COLS*PIX_W +: WIN_COLS*PIX_W])
    );
  end

  // two-row-delayed stream for chaining, always from the internal lines
  always_ff @(posedge clk or negedge dp_rst_n) begin
    if (!dp_rst_n) casc_q <= '0;
    else if (adv)  casc_q <= ld_out[LINE_CNT-1];
  end
  assign casc_out = casc_q;
endmodule

// File: rtl/lbw_window_gen_chk.sv
module lbw_window_gen_chk #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_n,
  input logic               hold,
  input logic               cfg_we,
  input logic               in_valid,
  input logic               in_ready,
  input logic [PIX_W-1:0]   in_pix,
  input logic [9*PIX_W-1:0] win_flat,
  input logic               win_valid,
  input logic [PIX_W-1:0]   casc_out
);
  // R2: hold blocks acceptance on the following cycle
  a_r2_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !in_ready);
  a_r2_ready_on: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> in_ready);

  // R3: newest column loads the accepted pixel, older columns shift
  a_r3_col0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && frame_n) |=>
      (!frame_n || win_flat[PIX_W-1:0] == $past(in_pix)));
  a_r3_col_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && frame_n) |=>
      (!frame_n || win_flat[2*PIX_W-1:PIX_W] == $past(win_flat[PIX_W-1:0])));

  // R6: the window becomes valid only through an accepted pixel
  a_r6_valid_on_accept: assert property (@(posedge clk) disable iff (!rst_n || !frame_n)
    ($rose(win_valid) && $past(!cfg_we)) |-> $past(in_valid && in_ready));

  // R9: frame clear empties the datapath
  a_r9_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (!win_valid && casc_out == '0 && win_flat == '0));

  // R10: nothing moves while the input is stalled
  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && frame_n) |=>
      (!frame_n || ($stable(win_flat) && $stable(casc_out) && $stable(win_valid))));
endmodule

bind lbw_window_gen lbw_window_gen_chk #(.PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .hold     (hold),
  .cfg_we   (cfg_we),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_pix   (in_pix),
  .win_flat (win_flat),
  .win_valid(win_valid),
  .casc_out (casc_out)
);

// File: tb/tb_lbw_window_gen.sv
module tb_lbw_window_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        hold = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_len = '0;
  logic        cfg_ext = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_pix = '0;
  logic [15:0] ext_rows = '0;
  logic [71:0] win_flat;
  logic        win_valid;
  logic [7:0]  casc_out;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  int L      = 1024;
  bit md     = 1'b0;
  bit hq     = 1'b0;
  int hist [0:4200];
  int e1   [0:4200];
  int e2   [0:4200];
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lbw_window_gen dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .hold(hold),
    .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_ext(cfg_ext),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .ext_rows(ext_rows), .win_flat(win_flat), .win_valid(win_valid),
    .casc_out(casc_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (n=%0d)", req, act, exp, n);
    end
  endtask

  function automatic int pv(input int k, input int s);
    return (k * s + 17) & 255;
  endfunction

  function automatic int exp_tap(input int r, input int c);
    int idx;
    if (r > 0 && md) begin
      idx = n - c;
      if (idx < 1) return 0;
      return (r == 1) ? e1[idx] : e2[idx];
    end
    idx = n - r * L - c;
    return (idx >= 1) ? hist[idx] : 0;
  endfunction

  task automatic check_all();
    int ci;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        if (r == 0)  chk("R3", 32'(win_flat[(r*3+c)*8 +: 8]), 32'(exp_tap(r, c)));
        else if (md) chk("R7", 32'(win_flat[(r*3+c)*8 +: 8]), 32'(exp_tap(r, c)));
        else         chk("R4", 32'(win_flat[(r*3+c)*8 +: 8]), 32'(exp_tap(r, c)));
      end
    end
    ci = n - 2 * L;
    chk("R5", 32'(casc_out), 32'((ci >= 1) ? hist[ci] : 0));
    chk("R6", 32'(win_valid), 32'(n >= 2 * L + 3));
    chk("R2", 32'(in_ready), 32'(!hq));
  endtask

  task automatic step(input logic v, input int p, input int e, input logic h);
    @(negedge clk);
    in_valid = v; in_pix = 8'(p); ext_rows = 16'(e); hold = h;
    @(posedge clk);
    if (v && !hq) begin
      n++; hist[n] = p & 255; e1[n] = e & 255; e2[n] = (e >> 8) & 255;
    end
    hq = hold;
    #1;
  endtask

  task automatic cfg(input int len, input logic ext, input logic h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len = 11'(len); cfg_ext = ext; hold = h; in_valid = 1'b0;
    @(posedge clk);
    if (!hq) begin
      L  = (len == 0 || len > 1024) ? 1024 : len;
      md = ext;
    end
    hq = hold;
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic frame_clear();
    @(negedge clk);
    frame_n = 1'b0; in_valid = 1'b0;
    @(posedge clk);
    hq = hold;
    #1;
    n = 0;
    chk("R9", 32'(win_flat[31:0]), 32'h0);
    chk("R9", 32'(win_flat[71:32]), 32'h0);
    chk("R9", 32'(casc_out), 32'h0);
    chk("R9", 32'(win_valid), 32'h0);
    frame_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", 32'(win_flat[31:0]), 32'h0);
    chk("R1", 32'(win_flat[71:32]), 32'h0);
    chk("R1", 32'(casc_out), 32'h0);
    chk("R1", 32'(win_valid), 32'h0);
    chk("R1", 32'(in_ready), 32'h1);
  endtask

  // R3 R4 R5 R6 with a short row
  task automatic t_basic();
    cfg(4, 1'b0, 1'b0);
    frame_clear();
    for (int k = 1; k <= 20; k++) begin
      step(1'b1, pv(k, 29), 0, 1'b0);
      check_all();
    end
  endtask

  // R2: idle cycles in the stream are not accepted
  task automatic t_gaps();
    cfg(5, 1'b0, 1'b0);
    frame_clear();
    for (int k = 1; k <= 36; k++) begin
      step(k % 3 != 0, pv(k, 53), 0, 1'b0);
      check_all();
    end
  endtask

  // R10 freeze and R8 write ignored while stalled
  task automatic t_hold();
    logic [71:0] snap;
    logic [7:0]  csnap;
    cfg(4, 1'b0, 1'b0);
    frame_clear();
    for (int k = 1; k <= 6; k++) step(1'b1, pv(k, 11), 0, 1'b0);
    step(1'b1, pv(7, 11), 0, 1'b1);
    check_all();
    snap = win_flat; csnap = casc_out;
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 8'hA5 + k, 0, 1'b1);
      chk("R10", 32'(win_flat[31:0]), 32'(snap[31:0]));
      chk("R10", 32'(win_flat[71:32]), 32'(snap[71:32]));
      chk("R10", 32'(casc_out), 32'(csnap));
      check_all();
    end
    cfg(7, 1'b0, 1'b1);
    chk("R8", 32'(L), 32'd4);
    step(1'b1, 8'h3C, 0, 1'b0);
    check_all();
    for (int k = 8; k <= 22; k++) begin
      step(1'b1, pv(k, 11), 0, 1'b0);
      check_all();
    end
  endtask

  // R7 external rows replace the line delays
  task automatic t_ext();
    cfg(4, 1'b1, 1'b0);
    frame_clear();
    for (int k = 1; k <= 16; k++) begin
      step(1'b1, pv(k, 7), (pv(k, 91) << 8) | pv(k, 45), 1'b0);
      check_all();
    end
    cfg(4, 1'b0, 1'b0);
  endtask

  // R9 frame clear while hold is active keeps the row length
  task automatic t_frame_hold();
    cfg(3, 1'b0, 1'b0);
    frame_clear();
    for (int k = 1; k <= 12; k++) step(1'b1, pv(k, 77), 0, 1'b0);
    check_all();
    step(1'b1, 8'h11, 0, 1'b1);
    step(1'b1, 8'h22, 0, 1'b1);
    frame_clear();
    chk("R9", 32'(in_ready), 32'h0);
    for (int k = 1; k <= 15; k++) begin
      step(1'b1, pv(k, 123), 0, 1'b0);
      check_all();
    end
  endtask

  // R8 out-of-range lengths select the full line
  task automatic t_clamp(input int len);
    cfg(len, 1'b0, 1'b0);
    chk("R8", 32'(L), 32'd1024);
    frame_clear();
    for (int k = 1; k <= 2052; k++) begin
      step(1'b1, pv(k, 3), 0, 1'b0);
      if (k == 1024 || k == 1025 || k == 1027 || k >= 2049) begin
        check_all();
        chk("R8", 32'(win_valid), 32'(k >= 2051));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_gaps();
    t_hold();
    t_ext();
    t_frame_hold();
    t_clamp(0);
    t_clamp(1500);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule